// File: doc/BRIEF.md
# Round-Robin Thread Context Scheduler

This block decides which of up to eight hardware thread contexts currently owns a single-issue packet-processing engine. Running several contexts on one engine hides memory latency. A context that starts a long memory access gives the engine up, and another context does useful work while it waits. The running context is never forced off the engine. It keeps ownership until it raises a yield pulse. The scheduler then hands the engine to the next ready context in circular order, and the search begins just after the context that yielded.

Each context has a ready bit. A context that yields becomes not-ready. A wake pulse from the memory units or any other source sets the bit again. If no eligible context is ready, the valid output drops and the engine idles until a wake arrives. A run-time half-mode input restricts scheduling to the even-numbered contexts, so the engine can be run with four contexts instead of eight.

Top module: `ctx_rr_sched`

## Requirements
- R1: While reset is asserted and after it is released, the active context number is 0 and the valid flag is 1. Context 0 is the only ready context.
- R2: While valid is 1 and no yield is presented, the active context number and valid stay unchanged at the next clock edge, whatever the wake inputs do.
- R3: A yield presented while valid is 1 selects, at the next edge, the first ready eligible context found in the order active+1, active+2, … wrapping modulo 8. The yielding context itself is checked last.
- R4: The yielding context becomes not-ready unless its own wake bit is set in the same cycle. If no other eligible context is ready, valid becomes 0 at the next edge.
- R5: A wake and a yield for the running context in the same cycle leave it ready. If it is the only ready eligible context, it is selected again and valid stays 1.
- R6: While valid is 0, the active context number keeps the last context that ran. A wake bit set in a cycle makes that context selectable at the next edge, with valid 1. The search starts after the last context that ran.
- R7: When half_mode is 1, only contexts 0, 2, 4 and 6 can be selected. Odd contexts that are ready stay ready and can be selected after half_mode returns to 0.
- R8: A yield presented while valid is 0 has no effect.
- R9: A wake bit for the context that is already running has no visible effect while it runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wake_i | input | 8 | Per-context wake pulses; bit i makes context i ready |
| yield_i | input | 1 | Running context gives up the engine this cycle |
| half_mode_i | input | 1 | 1: only even contexts take part; 0: all eight |
| act_ctx_o | output | 3 | Number of the context that owns the engine |
| act_vld_o | output | 1 | 1 when act_ctx_o is running; 0 when the engine idles |

## Verification
The assertions check on every cycle that the running context is held without a yield, that the running context is always ready, and that a yielding context loses its ready bit unless it was woken in the same cycle. They also check that half mode never selects an odd context, and that a woken yielder keeps the engine valid. Only the bench scenarios show the circular search order and its wrap-around, the idle-and-wake sequence with its rotation origin, and odd contexts that wait through half mode and are served afterwards. The bench checks these against a cycle model, over directed cases and a long random run.

// File: rtl/ctx_sched_pkg.sv
package ctx_sched_pkg;
  localparam int unsigned CTX_N = 8;
  localparam int unsigned CTX_W = $clog2(CTX_N);
  typedef logic [CTX_N-1:0] ctx_vec_t;
  typedef logic [CTX_W-1:0] ctx_id_t;
endpackage

// File: rtl/ctx_elig_mask.sv
module ctx_elig_mask #(
  parameter int unsigned N = 8
) (
  input  logic         half_mode,
  output logic [N-1:0] elig
);
  for (genvar i = 0; i < N; i++) begin : g_elig
    if ((i % 2) == 0) begin : g_even
      assign elig[i] = 1'b1;
    end else begin : g_odd
      assign elig[i] = ~half_mode;
    end
  end
endmodule

// File: rtl/ctx_ready_track.sv
module ctx_ready_track #(
  parameter int unsigned N = 8,
  localparam int unsigned W = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] wake,
  input  logic         take,
  input  logic [W-1:0] run_id,
  output logic [N-1:0] rdy_q,
  output logic [N-1:0] rdy_nxt
);
  logic [N-1:0] clr_vec;
  logic         rdy_en;

  always_comb begin
    clr_vec = '0;
    if (take) clr_vec[run_id] = 1'b1;
    rdy_nxt = (rdy_q & ~clr_vec) | wake;
    rdy_en  = take | (|wake);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= N'(1);
    end else if (rdy_en) begin
      rdy_q <= rdy_nxt;
    end
  end

  // R4: yielder loses its ready bit unless woken in the same cycle
  p_yield_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !wake[run_id]) |=> !rdy_q[$past(run_id)]);
endmodule

// File: rtl/ctx_rr_pick.sv
module ctx_rr_pick #(
  parameter int unsigned N = 8,
  localparam int unsigned W = $clog2(N)
) (
  input  logic [N-1:0] cand,
  input  logic [W-1:0] last_id,
  output logic         found,
  output logic [W-1:0] pick_id
);
  always_comb begin
    found   = 1'b0;
    pick_id = last_id;
    for (int k = 1; k <= N; k++) begin
      logic [W-1:0] idx;
      idx = last_id + W'(k);
      if (!found && cand[idx]) begin
        found   = 1'b1;
        pick_id = idx;
      end
    end
  end
endmodule

// File: rtl/ctx_rr_sched.sv
module ctx_rr_sched
  import ctx_sched_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CTX_N-1:0] wake_i,
  input  logic             yield_i,
  input  logic             half_mode_i,
  output logic [CTX_W-1:0] act_ctx_o,
  output logic             act_vld_o
);
  ctx_vec_t elig, rdy_q, rdy_nxt, cand;
  ctx_id_t  act_q, act_d, pick_id;
  logic     vld_q, vld_d, found, take, sw_en;

  assign take = vld_q & yield_i;
  assign sw_en = ~vld_q | take;
  assign cand = rdy_nxt & elig;

  ctx_elig_mask #(.N(CTX_N)) u_mask (
    .half_mode (half_mode_i),
    .elig      (elig)
  );

  ctx_ready_track #(.N(CTX_N)) u_rdy (
    .clk     (clk),
    .rst_n   (rst_n),
    .wake    (wake_i),
    .take    (take),
    .run_id  (act_q),
    .rdy_q   (rdy_q),
    .rdy_nxt (rdy_nxt)
  );

  ctx_rr_pick #(.N(CTX_N)) u_pick (
    .cand    (cand),
    .last_id (act_q),
    .found   (found),
    .pick_id (pick_id)
  );

  always_comb begin
    act_d = act_q;
    vld_d = vld_q;
    if (sw_en) begin
      vld_d = found;
      if (found) act_d = pick_id;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
      vld_q <= 1'b1;
    end else if (sw_en) begin
      act_q <= act_d;
      vld_q <= vld_d;
    end
  end

  assign act_ctx_o = act_q;
  assign act_vld_o = vld_q;

  // R2: no preemption
  p_hold_no_yield_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (act_vld_o && !yield_i) |=> (act_vld_o && $stable(act_ctx_o)));
  // R9: the running context is always ready
  p_run_is_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    act_vld_o |-> rdy_q[act_ctx_o]);
  // R7: half mode selects only even contexts
  p_even_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((!act_vld_o || yield_i) && half_mode_i) |=> (!act_vld_o || !act_ctx_o[0]));
  // R5: a woken yielder keeps the engine busy
  p_wake_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (act_vld_o && yield_i && wake_i[act_ctx_o] && (!half_mode_i || !act_ctx_o[0]))
      |=> act_vld_o);
endmodule

// File: tb/tb_ctx_rr_sched.sv
module tb_ctx_rr_sched;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] wake;
  logic       yld;
  logic       half;
  logic [2:0] act;
  logic       vld;

  int total = 0;
  int bad = 0;
  bit done = 0;

  bit [7:0] m_rdy;
  bit [2:0] m_act;
  bit       m_vld;

  always #5 clk = ~clk;

  ctx_rr_sched dut (
    .clk(clk), .rst_n(rst_n), .wake_i(wake), .yield_i(yld),
    .half_mode_i(half), .act_ctx_o(act), .act_vld_o(vld)
  );

  function automatic void model_step(bit [7:0] w, bit y, bit h);
    bit [7:0] nr, el, cnd;
    bit       tk, fnd;
    bit [2:0] idx;
    tk = m_vld && y;
    nr = m_rdy;
    if (tk) nr[m_act] = 1'b0;
    nr = nr | w;
    if (!m_vld || tk) begin
      el = h ? 8'h55 : 8'hFF;
      cnd = nr & el;
      fnd = 0;
      for (int k = 1; k <= 8; k++) begin
        idx = m_act + 3'(k);
        if (!fnd && cnd[idx]) begin
          fnd = 1;
          m_act = idx;
        end
      end
      m_vld = fnd;
    end
    m_rdy = nr;
  endfunction

  task automatic check(string tag, bit [2:0] e_act, bit e_vld);
    total++;
    if (act !== e_act || vld !== e_vld) begin
      bad++;
      $display("FAIL %s: act=%0d vld=%0b expected act=%0d vld=%0b",
               tag, act, vld, e_act, e_vld);
    end
  endtask

  task automatic step(bit [7:0] w, bit y, bit h);
    wake = w; yld = y; half = h;
    model_step(w, y, h);
    @(negedge clk);
  endtask

  task automatic step_chk(string tag, bit [7:0] w, bit y, bit h);
    step(w, y, h);
    check(tag, m_act, m_vld);
  endtask

  initial begin
    rst_n = 1'b0; wake = '0; yld = 1'b0; half = 1'b0;
    m_rdy = 8'h01; m_act = 0; m_vld = 1;
    repeat (3) @(negedge clk);
    check("R1 in reset", 3'd0, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", 3'd0, 1'b1);

    // R4: sole ready context yields -> idle
    step_chk("R4 yield to idle", 8'h00, 1, 0);
    check("R4 valid drops", 3'd0, 1'b0);
    // R8: yield while idle ignored
    step_chk("R8 idle yield", 8'h00, 1, 0);
    check("R8 still idle", 3'd0, 1'b0);
    // R6: wake context 5
    step_chk("R6 wake", 8'h20, 0, 0);
    check("R6 picks 5", 3'd5, 1'b1);
    // R2/R9: wakes while running, no yield
    step_chk("R2 hold", 8'h48, 0, 0);
    step_chk("R9 wake self", 8'h20, 0, 0);
    check("R2 still 5", 3'd5, 1'b1);
    // R3: ready {3,6}, yield from 5 -> 6, then 6 yields -> wrap to 3
    step_chk("R3 next after 5", 8'h00, 1, 0);
    check("R3 got 6", 3'd6, 1'b1);
    step_chk("R3 wrap", 8'h00, 1, 0);
    check("R3 got 3", 3'd3, 1'b1);
    // R5: woken yielder reselected
    step_chk("R5 wake+yield", 8'h08, 1, 0);
    check("R5 keeps 3", 3'd3, 1'b1);
    // R7: ready 1 and 2 in half mode, from 3 -> 1 skipped, picks 2? order 4..,0,1,2
    step_chk("R7 wake", 8'h06, 0, 1);
    step_chk("R7 yield", 8'h00, 1, 1);
    check("R7 even pick", 3'd2, 1'b1);
    step_chk("R7 yield 2", 8'h00, 1, 1);
    check("R7 idle with odd ready", 3'd2, 1'b0);
    step_chk("R7 leave half", 8'h00, 0, 0);
    check("R7 odd served", 3'd1, 1'b1);

    // random phase
    void'($urandom(32'd4242));
    begin
      bit h = 0;
      for (int i = 0; i < 4000; i++) begin
        bit [7:0] w;
        w = 8'($urandom & $urandom & $urandom);
        if (($urandom % 4) == 0) w = '0;
        if (($urandom % 50) == 0) h = ~h;
        step_chk("R3 R4 R6 R7 random", w, 1'($urandom % 2), h);
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: act=%0d vld=%0b expected act=done vld=done", act, vld);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule